// File: doc/BRIEF.md
# Operate Unit with Register File and Sign Flags

This block is the integer execute slice of a small 16-bit load/store processor. It holds eight 16-bit general registers and carries out the three operate instructions: addition, bitwise AND and bitwise complement. For each valid 16-bit instruction word it decodes the register fields, picks the second operand, computes the result, writes it back and updates a three-bit negative/zero/positive status. Instruction fetch, memory and program-counter handling belong to other units.

Other units write results into the register file through a separate load port. The same port can also move the status flags to match the loaded value. A combinational peek port reads any register, so a neighbour or a test can observe the register contents. Every state change happens on the rising clock edge that follows the request.

Top module: `op_regfile_alu`

## Requirements
- R1: While `rst_n` is low, and at the first edge after its release, every register reads 0 and `flags_o` is 3'b010 (zero only).
- R2: The opcode sits in `instr_i[15:12]`, with add = 4'b0001, and = 4'b0101 and complement = 4'b1001. The destination index sits in `instr_i[11:9]` and the first source index in `instr_i[8:6]`.
- R3: For add and and, `instr_i[5]` = 1 selects `instr_i[4:0]` sign-extended to 16 bits as the second operand. `instr_i[5]` = 0 selects the register indexed by `instr_i[2:0]`.
- R4: Complement writes the bitwise inverse of the first source and ignores `instr_i[5:0]`.
- R5: Add is two's-complement addition modulo 2^16, with no overflow indication. And is bitwise.
- R6: `flags_o` is {N,Z,P} in bits 2,1,0. Exactly one bit is always set. After every operate write, the flags reflect the sign of the 16-bit result (bit 15 set gives N, all zero gives Z, otherwise P).
- R7: The write-back lands on the rising edge that samples `instr_valid_i`. Source reads in the same cycle see the values from before that edge.
- R8: `ld_en_i` writes `ld_data_i` to register `ld_idx_i` on the edge. With `ld_flags_i` = 1 the flags also follow the sign of `ld_data_i`. With `ld_flags_i` = 0 the flags keep their value.
- R9: When a valid operate instruction and a load arrive in the same cycle, the instruction is performed and the load is discarded.
- R10: Any other opcode, or `instr_valid_i` low, leaves every register and the flags unchanged when no load is requested.
- R11: `peek_data_o` shows, in the same cycle, the register indexed by `peek_idx_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_i | input | 16 | Instruction word |
| instr_valid_i | input | 1 | Instruction word is valid this cycle |
| ld_en_i | input | 1 | Load port write request |
| ld_idx_i | input | 3 | Load port destination register |
| ld_data_i | input | 16 | Load port data |
| ld_flags_i | input | 1 | Load also updates the flags |
| peek_idx_i | input | 3 | Register index to observe |
| peek_data_o | output | 16 | Contents of the observed register |
| flags_o | output | 3 | Status flags {N,Z,P} |

## Verification
On every cycle the assertions check the flag invariants: that exactly one flag is set, that the flags hold through ignored opcodes, idle cycles and loads without flag update, and that a complement or a flag-setting load leaves the sign of the value that was computed or supplied. The register contents need the scenarios. Only the bench's reference model, compared register by register through the peek port, shows the operand selection, the immediate sign extension, the wrap of the sum, which side wins when an instruction and a load collide, and that same-cycle source reads return pre-edge values.

// File: rtl/opx_pkg.sv
`timescale 1ns/1ps
package opx_pkg;

    localparam int INSTR_W = 16;

    localparam logic [3:0] OPC_ADD = 4'b0001;
    localparam logic [3:0] OPC_AND = 4'b0101;
    localparam logic [3:0] OPC_NOT = 4'b1001;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_AND = 2'd1,
        ALU_INV = 2'd2
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic p;
    } nzp_t;

    localparam nzp_t NZP_RESET = '{n: 1'b0, z: 1'b1, p: 1'b0};

endpackage

// File: rtl/opx_decode.sv
`timescale 1ns/1ps
module opx_decode
    import opx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 3,
    parameter int IMM_W  = 5
) (
    input  logic [INSTR_W-1:0] instr_i,
    input  logic               valid_i,
    output logic               fire_o,
    output alu_op_e            alu_op_o,
    output logic [IDX_W-1:0]   dst_o,
    output logic [IDX_W-1:0]   src1_o,
    output logic [IDX_W-1:0]   src2_o,
    output logic               use_imm_o,
    output logic [DATA_W-1:0]  imm_o
);
    localparam int OPC_LSB  = INSTR_W - 4;
    localparam int DST_LSB  = OPC_LSB - IDX_W;
    localparam int SRC1_LSB = DST_LSB - IDX_W;
    localparam int MODE_BIT = IMM_W;
    localparam int EXT_W    = DATA_W - IMM_W;

    logic [3:0] opcode;
    logic       known;

    assign opcode = instr_i[INSTR_W-1:OPC_LSB];
    assign dst_o  = instr_i[DST_LSB +: IDX_W];
    assign src1_o = instr_i[SRC1_LSB +: IDX_W];
    assign src2_o = instr_i[IDX_W-1:0];
    assign imm_o  = {{EXT_W{instr_i[IMM_W-1]}}, instr_i[IMM_W-1:0]};

    always_comb begin
        known     = 1'b1;
        alu_op_o  = ALU_ADD;
        use_imm_o = instr_i[MODE_BIT];
        unique case (opcode)
            OPC_ADD: alu_op_o = ALU_ADD;
            OPC_AND: alu_op_o = ALU_AND;
            OPC_NOT: begin
                alu_op_o  = ALU_INV;
                use_imm_o = 1'b0;
            end
            default: known = 1'b0;
        endcase
    end

    assign fire_o = valid_i && known;

endmodule

// File: rtl/opx_alu.sv
`timescale 1ns/1ps
module opx_alu
    import opx_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] y_o
);
    always_comb begin
        unique case (op_i)
            ALU_ADD: y_o = a_i + b_i;
            ALU_AND: y_o = a_i & b_i;
            ALU_INV: y_o = ~a_i;
            default: y_o = '0;
        endcase
    end
endmodule

// File: rtl/opx_nzp.sv
`timescale 1ns/1ps
module opx_nzp
    import opx_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] value_i,
    output nzp_t              flags_o
);
    always_comb begin
        flags_o.n = value_i[DATA_W-1];
        flags_o.z = (value_i == '0);
        flags_o.p = !value_i[DATA_W-1] && (value_i != '0);
    end
endmodule

// File: rtl/opx_regfile.sv
`timescale 1ns/1ps
module opx_regfile #(
    parameter int DATA_W = 16,
    parameter int NREG   = 8,
    parameter int IDX_W  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  widx_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]  ra_i,
    output logic [DATA_W-1:0] ra_data_o,
    input  logic [IDX_W-1:0]  rb_i,
    output logic [DATA_W-1:0] rb_data_o,
    input  logic [IDX_W-1:0]  rp_i,
    output logic [DATA_W-1:0] rp_data_o
);
    logic [NREG-1:0][DATA_W-1:0] regs_d;
    logic [NREG-1:0][DATA_W-1:0] regs_q;

    for (genvar gi = 0; gi < NREG; gi++) begin : g_cell
        assign regs_d[gi] = (we_i && (widx_i == IDX_W'(gi))) ? wdata_i : regs_q[gi];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ra_data_o = regs_q[ra_i];
    assign rb_data_o = regs_q[rb_i];
    assign rp_data_o = regs_q[rp_i];

endmodule

// File: rtl/op_regfile_alu.sv
`timescale 1ns/1ps
module op_regfile_alu
    import opx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NREG   = 8,
    parameter int IMM_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic               instr_valid_i,
    input  logic               ld_en_i,
    input  logic [$clog2(NREG)-1:0] ld_idx_i,
    input  logic [DATA_W-1:0]  ld_data_i,
    input  logic               ld_flags_i,
    input  logic [$clog2(NREG)-1:0] peek_idx_i,
    output logic [DATA_W-1:0]  peek_data_o,
    output logic [2:0]         flags_o
);
    localparam int IDX_W = $clog2(NREG);

    typedef struct packed {
        nzp_t flags;
    } state_t;

    state_t st_d;
    state_t st_q;

    logic              op_fire;
    alu_op_e           alu_op;
    logic [IDX_W-1:0]  dst_idx;
    logic [IDX_W-1:0]  src1_idx;
    logic [IDX_W-1:0]  src2_idx;
    logic              use_imm;
    logic [DATA_W-1:0] imm_val;
    logic [DATA_W-1:0] rs1_data;
    logic [DATA_W-1:0] rs2_data;
    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] alu_y;
    logic [DATA_W-1:0] wr_data;
    nzp_t              wr_flags;
    logic              rf_we;
    logic [IDX_W-1:0]  rf_widx;

    opx_decode #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W),
        .IMM_W  (IMM_W)
    ) u_dec (
        .instr_i   (instr_i),
        .valid_i   (instr_valid_i),
        .fire_o    (op_fire),
        .alu_op_o  (alu_op),
        .dst_o     (dst_idx),
        .src1_o    (src1_idx),
        .src2_o    (src2_idx),
        .use_imm_o (use_imm),
        .imm_o     (imm_val)
    );

    opx_regfile #(
        .DATA_W (DATA_W),
        .NREG   (NREG),
        .IDX_W  (IDX_W)
    ) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (rf_we),
        .widx_i    (rf_widx),
        .wdata_i   (wr_data),
        .ra_i      (src1_idx),
        .ra_data_o (rs1_data),
        .rb_i      (src2_idx),
        .rb_data_o (rs2_data),
        .rp_i      (peek_idx_i),
        .rp_data_o (peek_data_o)
    );

    assign opnd_b = use_imm ? imm_val : rs2_data;

    opx_alu #(.DATA_W(DATA_W)) u_alu (
        .op_i (alu_op),
        .a_i  (rs1_data),
        .b_i  (opnd_b),
        .y_o  (alu_y)
    );

    // Operate result has priority over the load port for the single write port.
    assign wr_data = op_fire ? alu_y : ld_data_i;

    opx_nzp #(.DATA_W(DATA_W)) u_nzp (
        .value_i (wr_data),
        .flags_o (wr_flags)
    );

    always_comb begin
        st_d    = st_q;
        rf_we   = 1'b0;
        rf_widx = ld_idx_i;
        if (op_fire) begin
            rf_we      = 1'b1;
            rf_widx    = dst_idx;
            st_d.flags = wr_flags;
        end else if (ld_en_i) begin
            rf_we = 1'b1;
            if (ld_flags_i) begin
                st_d.flags = wr_flags;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flags <= NZP_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flags;

endmodule

// File: rtl/opx_chk.sv
`timescale 1ns/1ps
module opx_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       instr_i,
    input logic              instr_valid_i,
    input logic              ld_en_i,
    input logic              ld_flags_i,
    input logic [DATA_W-1:0] ld_data_i,
    input logic [DATA_W-1:0] rs1_data,
    input logic [2:0]        flags_o
);
    function automatic logic [2:0] sign_of(input logic [DATA_W-1:0] v);
        if (v[DATA_W-1])   return 3'b100;
        else if (v == '0)  return 3'b010;
        else               return 3'b001;
    endfunction

    logic is_op;
    logic is_inv;
    assign is_inv = instr_valid_i && (instr_i[15:12] == 4'b1001);
    assign is_op  = instr_valid_i && ((instr_i[15:12] == 4'b0001) ||
                                      (instr_i[15:12] == 4'b0101) || is_inv);

    a_r6_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(flags_o) == 1);

    a_r1_reset_flags: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> flags_o == 3'b010);

    a_r4_inv_flags: assert property (@(posedge clk) disable iff (!rst_n)
        is_inv |=> flags_o == sign_of(~$past(rs1_data)));

    a_r8_load_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en_i && ld_flags_i && !is_op) |=> flags_o == sign_of($past(ld_data_i)));

    a_r8_load_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en_i && !ld_flags_i && !is_op) |=> $stable(flags_o));

    a_r10_idle_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_op && !ld_en_i) |=> $stable(flags_o));

endmodule

bind op_regfile_alu opx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .instr_i       (instr_i),
    .instr_valid_i (instr_valid_i),
    .ld_en_i       (ld_en_i),
    .ld_flags_i    (ld_flags_i),
    .ld_data_i     (ld_data_i),
    .rs1_data      (rs1_data),
    .flags_o       (flags_o)
);

// File: tb/op_regfile_alu_tb.sv
`timescale 1ns/1ps
module op_regfile_alu_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr = '0;
    logic        valid = 1'b0;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_idx = '0;
    logic [15:0] ld_data = '0;
    logic        ld_flags = 1'b0;
    logic [2:0]  peek_idx = '0;
    logic [15:0] peek_data;
    logic [2:0]  flags;

    int checks = 0;
    int errors = 0;

    logic [15:0] ref_regs [8];
    logic [2:0]  ref_flags;

    always #2.5 clk = ~clk;

    op_regfile_alu u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .instr_i       (instr),
        .instr_valid_i (valid),
        .ld_en_i       (ld_en),
        .ld_idx_i      (ld_idx),
        .ld_data_i     (ld_data),
        .ld_flags_i    (ld_flags),
        .peek_idx_i    (peek_idx),
        .peek_data_o   (peek_data),
        .flags_o       (flags)
    );

    function automatic logic [2:0] exp_nzp(input logic [15:0] v);
        if (v[15])          return 3'b100;
        else if (v == 16'h0) return 3'b010;
        else                return 3'b001;
    endfunction

    function automatic logic [15:0] op_rr(input logic [3:0] op, input logic [2:0] d,
                                          input logic [2:0] s1, input logic [2:0] s2);
        return {op, d, s1, 3'b000, s2};
    endfunction

    function automatic logic [15:0] op_ri(input logic [3:0] op, input logic [2:0] d,
                                          input logic [2:0] s1, input logic [4:0] imm);
        return {op, d, s1, 1'b1, imm};
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(tag, "flags", {13'h0, flags}, {13'h0, ref_flags});
        for (int i = 0; i < 8; i++) begin
            peek_idx = 3'(i);
            #0.1;
            check(tag, $sformatf("reg %0d", i), peek_data, ref_regs[i]);
        end
    endtask

    // Drive one cycle of stimulus, advance the model, then compare after the edge.
    task automatic step(input string tag, input logic [15:0] ins, input logic v,
                        input logic le, input logic [2:0] li,
                        input logic [15:0] ld, input logic lf);
        logic [3:0]  op;
        logic        is_op;
        logic [15:0] a;
        logic [15:0] b;
        logic [15:0] r;
        instr = ins; valid = v; ld_en = le; ld_idx = li; ld_data = ld; ld_flags = lf;
        op    = ins[15:12];
        is_op = v && (op == 4'b0001 || op == 4'b0101 || op == 4'b1001);
        a     = ref_regs[ins[8:6]];
        b     = ins[5] ? {{11{ins[4]}}, ins[4:0]} : ref_regs[ins[2:0]];
        r     = '0;
        if (is_op) begin
            case (op)
                4'b0001: r = a + b;
                4'b0101: r = a & b;
                default: r = ~a;
            endcase
            ref_regs[ins[11:9]] = r;
            ref_flags = exp_nzp(r);
        end else if (le) begin
            ref_regs[li] = ld;
            if (lf) ref_flags = exp_nzp(ld);
        end
        @(posedge clk);
        #1;
        valid = 1'b0;
        ld_en = 1'b0;
        check_all(tag);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 8; i++) ref_regs[i] = '0;
        ref_flags = 3'b010;

        // R1: reset state, during reset and after release
        repeat (3) @(posedge clk);
        #1;
        check_all("R1");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check_all("R1");

        // R8: loads with and without flag update
        step("R8", '0, 1'b0, 1'b1, 3'd1, 16'h1234, 1'b1);
        step("R8", '0, 1'b0, 1'b1, 3'd2, 16'h8001, 1'b0);
        // R2 R3 R5: register-register add -> 0x9235, N
        step("R2", op_rr(4'b0001, 3'd3, 3'd1, 3'd2), 1'b1, 1'b0, '0, '0, 1'b0);
        // R3: immediate -2
        step("R3", op_ri(4'b0001, 3'd4, 3'd1, 5'b11110), 1'b1, 1'b0, '0, '0, 1'b0);
        // R3: and with 5'h10 sign-extended to 0xFFF0 -> 0x8000
        step("R3", op_ri(4'b0101, 3'd5, 3'd2, 5'b10000), 1'b1, 1'b0, '0, '0, 1'b0);
        // R5: and with zero clears, Z
        step("R5", op_ri(4'b0101, 3'd1, 3'd1, 5'b00000), 1'b1, 1'b0, '0, '0, 1'b0);
        // R4: complement with junk in low bits
        step("R4", {4'b1001, 3'd7, 3'd2, 6'b110101}, 1'b1, 1'b0, '0, '0, 1'b0);
        // R5: wrap 0x7FFF + 1 -> 0x8000
        step("R5", '0, 1'b0, 1'b1, 3'd0, 16'h7FFF, 1'b0);
        step("R5", op_ri(4'b0001, 3'd0, 3'd0, 5'b00001), 1'b1, 1'b0, '0, '0, 1'b0);
        // R5: wrap 0xFFFF + 1 -> 0, Z
        step("R5", '0, 1'b0, 1'b1, 3'd6, 16'hFFFF, 1'b1);
        step("R5", op_ri(4'b0001, 3'd6, 3'd6, 5'b00001), 1'b1, 1'b0, '0, '0, 1'b0);
        // R10: unknown opcodes and valid low
        step("R10", op_ri(4'b0011, 3'd3, 3'd2, 5'b00001), 1'b1, 1'b0, '0, '0, 1'b0);
        step("R10", 16'hFFFF, 1'b1, 1'b0, '0, '0, 1'b0);
        step("R10", op_rr(4'b0001, 3'd3, 3'd3, 3'd3), 1'b0, 1'b0, '0, '0, 1'b0);
        // R9: instruction and load together, load dropped
        step("R9", op_ri(4'b0001, 3'd4, 3'd4, 5'b00011), 1'b1, 1'b1, 3'd5, 16'h0042, 1'b1);
        // R9: unknown opcode does not block the load
        step("R9", 16'hD000, 1'b1, 1'b1, 3'd5, 16'h0042, 1'b1);
        // R7: back-to-back dependent updates, source reads pre-edge value
        step("R7", op_rr(4'b0001, 3'd2, 3'd2, 3'd2), 1'b1, 1'b0, '0, '0, 1'b0);
        step("R7", op_rr(4'b0001, 3'd2, 3'd2, 3'd2), 1'b1, 1'b0, '0, '0, 1'b0);
        // R11 R6: peek sweep is part of every step; one more positive result
        step("R11", '0, 1'b0, 1'b1, 3'd7, 16'h0001, 1'b1);

        // R6: random mix of operate instructions and loads
        for (int n = 0; n < 500; n++) begin
            logic [15:0] ins;
            logic [3:0]  pick;
            pick = 4'($urandom_range(0, 9));
            ins  = 16'($urandom());
            case (pick)
                0, 1, 2: ins[15:12] = 4'b0001;
                3, 4:    ins[15:12] = 4'b0101;
                5, 6:    ins[15:12] = 4'b1001;
                default: ;
            endcase
            step("R6", ins, 1'($urandom_range(0, 7) != 0), 1'($urandom_range(0, 2) == 0),
                 3'($urandom()), 16'($urandom()), 1'($urandom()));
        end

        finish_run();
    end

    initial begin
        void'($urandom(32'd1979));
    end

endmodule